// File: doc/BRIEF.md
# System Exception Control Register Bank

This block is the software-visible face of the fixed system exceptions: non-maskable interrupt, periodic tick, deferred service call, memory-management fault, bus fault, usage fault, supervisor call and debug monitor. The interrupt controller supplies the live pending and active state of each of these exceptions. It also supplies the line number of the running exception, whether that exception preempted another, and the line number of the highest-priority pending request. From these the block builds two status words that software reads. Software writes to the same words turn into one-cycle set-pending and clear-pending strobes and into stored fault enables, which flow back to the controller.

Besides the status words, the bank holds a vector table base, aligned to 128 bytes. It also has a reset-control word that responds only to writes that carry the right key. A keyed write raises one-cycle requests to clear all active state or to reset the system. The bank does no priority arbitration; the controller does that.

Accesses are single whole words. A write is taken at the clock edge while `bus_wr` is high. Read data is combinational from `bus_addr`. The word offsets are 0x00 for the interrupt state word, 0x04 for the vector base, 0x08 for reset control and 0x0C for the handler state word. Every other offset reads 0 and ignores writes.

Top module: `sysexc_ctrl_bank`

## Requirements
- R1: Exception index order on `exc_pend`, `exc_act`, `set_pend` and `clr_pend` is 0 NMI, 1 memory fault, 2 bus fault, 3 usage fault, 4 supervisor call, 5 debug monitor, 6 deferred service call, 7 tick. After reset all strobes are 0, `fault_en` is 0 and the vector base reads 0.
- R2: Interrupt state word bits 8..0 give the active vector. A controller line of 1023 means no active exception and reads 0. Lines 32 and up are reported as line minus 16, and lower lines are reported unchanged.
- R3: Interrupt state word bit 11 is 1 when no exception is active, or when the active exception has not preempted another (`act_preempted` low).
- R4: Interrupt state word bits 20..12 give the pending vector, renumbered in the same way as in R2, and read 0 when `pend_line` is 1023. Bit 22 mirrors `ext_pend_any`. Bits 26, 28 and 31 are the pending state of tick, deferred service call and NMI.
- R5: A write to the interrupt state word with bit 31 pends NMI. Bit 28 pends the deferred service call, and bit 26 pends tick. Each strobe is high for exactly the one cycle after the write edge.
- R6: Bit 27 clears the deferred service call and bit 25 clears tick, but only when the matching set bit (28 or 26) in the same word is 0. Set wins.
- R7: Handler state word active bits: memory fault 0, bus fault 1, usage fault 3, supervisor call 7, debug monitor 8, deferred service call 10, tick 11.
- R8: Handler state word pending bits: usage fault 12, memory fault 13, bus fault 14, supervisor call 15. Bits 16, 17 and 18 read back the memory, bus and usage fault enables.
- R9: A write to the handler state word updates only `fault_en` (bit 16 to `fault_en[0]`, 17 to `[1]`, 18 to `[2]`) and raises no strobe.
- R10: The vector base stores the written word with bits 6..0 forced to 0. A reset returns it to 0.
- R11: The reset-control word reads 0xFA05_0000. A write whose upper half is 0x05FA raises `clr_active_req` for one cycle when bit 1 is set, and raises `sys_reset_req` for one cycle when bit 0 or bit 2 is set. A write with any other upper half has no effect.
- R12: Offsets outside the four registers read 0, and writes to them change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write enable, one word per cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| act_line | input | LINE_W | Controller line of the running exception, 1023 for none |
| act_preempted | input | 1 | Running exception preempted another |
| pend_line | input | LINE_W | Controller line of the highest pending request, 1023 for none |
| ext_pend_any | input | 1 | Any external interrupt pending |
| exc_pend | input | 8 | Pending state per system exception |
| exc_act | input | 8 | Active state per system exception |
| set_pend | output | 8 | One-cycle set-pending strobes |
| clr_pend | output | 8 | One-cycle clear-pending strobes |
| fault_en | output | 3 | Memory, bus and usage fault enables |
| clr_active_req | output | 1 | One-cycle request to clear all active state |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The state word is read under six controller snapshots. These cover idle, a low line that is not renumbered, lines at and above 32 that are, the boundary line 31, nesting on and off, and the idle case with nesting high, which separates the two causes of the return-to-base bit. The handler word snapshots light the active and pending groups apart, so a swapped bit position shows up. The write tests try set-only, set combined with clear, and clear-only words to isolate the set-wins rule. Keyed and unkeyed reset-control writes, and writes to an unmapped offset, show which writes must have no effect.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
    localparam int DATA_W  = 32;
    localparam int NUM_EXC = 8;
    localparam int NUM_FEN = 3;

    typedef enum logic [2:0] {
        EX_NMI  = 3'd0,
        EX_MEMF = 3'd1,
        EX_BUSF = 3'd2,
        EX_USGF = 3'd3,
        EX_SVC  = 3'd4,
        EX_DBGM = 3'd5,
        EX_PSV  = 3'd6,
        EX_TICK = 3'd7
    } exc_id_e;

    typedef enum logic [5:0] {
        OFF_STATE   = 6'h00,
        OFF_VBASE   = 6'h04,
        OFF_RSTCTL  = 6'h08,
        OFF_HANDLER = 6'h0C
    } reg_off_e;

    localparam logic [15:0] RST_WKEY    = 16'h05FA;
    localparam logic [15:0] RST_RKEY    = 16'hFA05;
    localparam int          VBASE_ALIGN = 7;
    localparam int          EXT_FIRST   = 32;
    localparam int          EXT_SHIFT   = 16;

    typedef struct packed {
        logic [NUM_EXC-1:0] set_v;
        logic [NUM_EXC-1:0] clr_v;
        logic               clr_act;
        logic               sys_rst;
    } strobe_t;
endpackage

// File: rtl/sysexc_read_fmt.sv
module sysexc_read_fmt
    import sysexc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LINE_W = 10,
    parameter int VEC_W  = 9
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [LINE_W-1:0]  act_line,
    input  logic               act_preempted,
    input  logic [LINE_W-1:0]  pend_line,
    input  logic               ext_pend_any,
    input  logic [NUM_EXC-1:0] exc_pend,
    input  logic [NUM_EXC-1:0] exc_act,
    input  logic [NUM_FEN-1:0] fault_en,
    input  logic [DATA_W-1:0]  vbase,
    output logic [DATA_W-1:0]  rdata
);
    localparam logic [LINE_W-1:0] IDLE_LINE = {LINE_W{1'b1}};
    localparam int PEND_LSB = 12;

    function automatic logic [VEC_W-1:0] renum(input logic [LINE_W-1:0] line);
        logic [LINE_W-1:0] v;
        if (line == IDLE_LINE)
            v = '0;
        else if (line >= LINE_W'(EXT_FIRST))
            v = line - LINE_W'(EXT_SHIFT);
        else
            v = line;
        return v[VEC_W-1:0];
    endfunction

    logic [DATA_W-1:0] state_w;
    logic [DATA_W-1:0] handler_w;
    logic              nothing_active;
    logic [LINE_W-1:0] unused_hi;

    assign nothing_active = (act_line == IDLE_LINE);
    assign unused_hi      = {exc_pend[EX_NMI], exc_pend[EX_DBGM], exc_act[EX_NMI],
                             {(LINE_W-3){1'b0}}};

    always_comb begin
        state_w                            = '0;
        state_w[VEC_W-1:0]                 = renum(act_line);
        state_w[11]                        = nothing_active || !act_preempted;
        state_w[PEND_LSB +: VEC_W]         = renum(pend_line);
        state_w[22]                        = ext_pend_any;
        state_w[26]                        = exc_pend[EX_TICK];
        state_w[28]                        = exc_pend[EX_PSV];
        state_w[31]                        = exc_pend[EX_NMI];
    end

    always_comb begin
        handler_w        = '0;
        handler_w[0]     = exc_act[EX_MEMF];
        handler_w[1]     = exc_act[EX_BUSF];
        handler_w[3]     = exc_act[EX_USGF];
        handler_w[7]     = exc_act[EX_SVC];
        handler_w[8]     = exc_act[EX_DBGM];
        handler_w[10]    = exc_act[EX_PSV];
        handler_w[11]    = exc_act[EX_TICK];
        handler_w[12]    = exc_pend[EX_USGF];
        handler_w[13]    = exc_pend[EX_MEMF];
        handler_w[14]    = exc_pend[EX_BUSF];
        handler_w[15]    = exc_pend[EX_SVC];
        handler_w[18:16] = fault_en;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_W'(OFF_STATE):   rdata = state_w;
            ADDR_W'(OFF_VBASE):   rdata = vbase;
            ADDR_W'(OFF_RSTCTL):  rdata = {RST_RKEY, 16'h0000};
            ADDR_W'(OFF_HANDLER): rdata = handler_w;
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysexc_write_dec.sv
module sysexc_write_dec
    import sysexc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output strobe_t            strobes,
    output logic [NUM_FEN-1:0] fault_en,
    output logic [DATA_W-1:0]  vbase
);
    logic    hit_state, hit_vbase, hit_rst, hit_handler, key_ok;
    strobe_t next_s;
    logic    unused_mid;

    assign hit_state   = wr && (addr == ADDR_W'(OFF_STATE));
    assign hit_vbase   = wr && (addr == ADDR_W'(OFF_VBASE));
    assign hit_rst     = wr && (addr == ADDR_W'(OFF_RSTCTL));
    assign hit_handler = wr && (addr == ADDR_W'(OFF_HANDLER));
    assign key_ok      = (wdata[31:16] == RST_WKEY);
    assign unused_mid  = ^wdata[6:3];

    // Set and clear pairs: each entry names the set bit and clear bit.
    typedef struct packed {
        logic [4:0] set_bit;
        logic       has_clr;
        logic [4:0] clr_bit;
    } pair_t;

    function automatic pair_t pair_of(input int idx);
        pair_t p;
        p = '0;
        case (idx)
            EX_NMI:  begin p.set_bit = 5'd31; end
            EX_PSV:  begin p.set_bit = 5'd28; p.has_clr = 1'b1; p.clr_bit = 5'd27; end
            EX_TICK: begin p.set_bit = 5'd26; p.has_clr = 1'b1; p.clr_bit = 5'd25; end
            default: ;
        endcase
        return p;
    endfunction

    always_comb begin
        next_s = '0;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (i == EX_NMI || i == EX_PSV || i == EX_TICK) begin
                next_s.set_v[i] = hit_state && wdata[pair_of(i).set_bit];
                next_s.clr_v[i] = hit_state && pair_of(i).has_clr
                                  && wdata[pair_of(i).clr_bit]
                                  && !wdata[pair_of(i).set_bit];
            end
        end
        next_s.clr_act = hit_rst && key_ok && wdata[1];
        next_s.sys_rst = hit_rst && key_ok && (wdata[0] || wdata[2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobes  <= '0;
            fault_en <= '0;
            vbase    <= '0;
        end else begin
            strobes <= next_s;
            if (hit_handler)
                fault_en <= wdata[16 +: NUM_FEN];
            if (hit_vbase)
                vbase <= {wdata[DATA_W-1:VBASE_ALIGN], {VBASE_ALIGN{1'b0}}};
        end
    end
endmodule

// File: rtl/sysexc_ctrl_bank.sv
module sysexc_ctrl_bank
    import sysexc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LINE_W = 10,
    parameter int VEC_W  = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [LINE_W-1:0]  act_line,
    input  logic               act_preempted,
    input  logic [LINE_W-1:0]  pend_line,
    input  logic               ext_pend_any,
    input  logic [7:0]         exc_pend,
    input  logic [7:0]         exc_act,
    output logic [7:0]         set_pend,
    output logic [7:0]         clr_pend,
    output logic [2:0]         fault_en,
    output logic               clr_active_req,
    output logic               sys_reset_req
);
    strobe_t           strobes;
    logic [DATA_W-1:0] vbase;

    sysexc_write_dec #(.ADDR_W(ADDR_W)) u_wdec (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .strobes  (strobes),
        .fault_en (fault_en),
        .vbase    (vbase)
    );

    sysexc_read_fmt #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .VEC_W(VEC_W)) u_rfmt (
        .rd_addr       (bus_addr),
        .act_line      (act_line),
        .act_preempted (act_preempted),
        .pend_line     (pend_line),
        .ext_pend_any  (ext_pend_any),
        .exc_pend      (exc_pend),
        .exc_act       (exc_act),
        .fault_en      (fault_en),
        .vbase         (vbase),
        .rdata         (bus_rdata)
    );

    assign set_pend       = strobes.set_v;
    assign clr_pend       = strobes.clr_v;
    assign clr_active_req = strobes.clr_act;
    assign sys_reset_req  = strobes.sys_rst;
endmodule

// File: rtl/sysexc_ctrl_bank_chk.sv
module sysexc_ctrl_bank_chk
    import sysexc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        set_pend,
    input logic [7:0]        clr_pend,
    input logic [2:0]        fault_en,
    input logic              clr_active_req,
    input logic              sys_reset_req
);
    // R5
    strobe_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_pend || |clr_pend) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_STATE)));

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pend & clr_pend) == 8'h00);

    // R9
    enable_only_by_handler_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_en) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_HANDLER)));

    // R10
    vbase_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(OFF_VBASE)) |-> (bus_rdata[6:0] == 7'd0));

    // R11
    rst_req_keyed_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_reset_req || clr_active_req) |->
            $past(bus_wr && bus_addr == ADDR_W'(OFF_RSTCTL) && bus_wdata[31:16] == RST_WKEY));

    // R11
    rst_read_key_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(OFF_RSTCTL)) |-> (bus_rdata == 32'hFA05_0000));
endmodule

bind sysexc_ctrl_bank sysexc_ctrl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .set_pend       (set_pend),
    .clr_pend       (clr_pend),
    .fault_en       (fault_en),
    .clr_active_req (clr_active_req),
    .sys_reset_req  (sys_reset_req)
);

// File: tb/test_sysexc_ctrl_bank.sv
`timescale 1ns/1ps
module test_sysexc_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [9:0]  act_line;
    logic        act_preempted;
    logic [9:0]  pend_line;
    logic        ext_pend_any;
    logic [7:0]  exc_pend;
    logic [7:0]  exc_act;
    logic [7:0]  set_pend;
    logic [7:0]  clr_pend;
    logic [2:0]  fault_en;
    logic        clr_active_req;
    logic        sys_reset_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sysexc_ctrl_bank i_sysexc_ctrl_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_line(act_line),
        .act_preempted(act_preempted), .pend_line(pend_line),
        .ext_pend_any(ext_pend_any), .exc_pend(exc_pend), .exc_act(exc_act),
        .set_pend(set_pend), .clr_pend(clr_pend), .fault_en(fault_en),
        .clr_active_req(clr_active_req), .sys_reset_req(sys_reset_req)
    );

    // act_line, preempted, pend_line, ext_any, exc_pend, exc_act, state word, handler word
    localparam int NV = 6;
    localparam logic [101:0] VECS [NV] = '{
        {10'd1023, 1'b0, 10'd1023, 1'b0, 8'h00, 8'h00, 32'h0000_0800, 32'h0000_0000},
        {10'd3,    1'b1, 10'd15,   1'b0, 8'h80, 8'h08, 32'h0400_F003, 32'h0000_0008},
        {10'd40,   1'b0, 10'd50,   1'b1, 8'h41, 8'hC0, 32'h9042_2818, 32'h0000_0C00},
        {10'd32,   1'b1, 10'd1023, 1'b0, 8'h1E, 8'h36, 32'h0000_0010, 32'h0000_F183},
        {10'd31,   1'b1, 10'd32,   1'b1, 8'h00, 8'h01, 32'h0041_001F, 32'h0000_0000},
        {10'd1023, 1'b1, 10'd2,    1'b0, 8'h00, 8'h00, 32'h0000_2800, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Drives one write; returns at the next falling edge where strobes are visible.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    function automatic logic [31:0] strobes_word();
        return {14'd0, sys_reset_req, clr_active_req, clr_pend, set_pend};
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        act_line = 10'd1023; act_preempted = 1'b0; pend_line = 10'd1023;
        ext_pend_any = 1'b0; exc_pend = '0; exc_act = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 strobes after reset", strobes_word(), 32'h0);
        chk("R1 enables after reset", {29'd0, fault_en}, 32'h0);
        rd(6'h04, d); chk("R1 vector base after reset", d, 32'h0);

        // R2 R3 R4 R7 R8 snapshot table
        for (int i = 0; i < NV; i++) begin
            logic [101:0] v;
            v = VECS[i];
            act_line = v[101:92]; act_preempted = v[91]; pend_line = v[90:81];
            ext_pend_any = v[80]; exc_pend = v[79:72]; exc_act = v[71:64];
            rd(6'h00, d); chk($sformatf("R2/R3/R4 state word vec %0d", i), d, v[63:32]);
            rd(6'h0C, d); chk($sformatf("R7/R8 handler word vec %0d", i), d, v[31:0]);
        end
        act_line = 10'd1023; pend_line = 10'd1023; ext_pend_any = 1'b0;
        exc_pend = '0; exc_act = '0; act_preempted = 1'b0;

        // R5 set bits 31,28,26
        wr(6'h00, 32'h9400_0000);
        chk("R5 set strobes", strobes_word(), 32'h0000_00C1);
        @(negedge clk);
        chk("R5 strobes last one cycle", strobes_word(), 32'h0);

        // R6 set PSV wins over its clear, tick clear honoured
        wr(6'h00, 32'h1A00_0000);
        chk("R6 set beats clear", strobes_word(), 32'h0000_8040);
        // R6 clear-only
        wr(6'h00, 32'h0800_0000);
        chk("R6 clear alone", strobes_word(), 32'h0000_4000);
        wr(6'h00, 32'h0600_0000);
        chk("R6 tick set beats tick clear", strobes_word(), 32'h0000_0080);

        // R9 handler write
        wr(6'h0C, 32'hFFFF_FFFF);
        chk("R9 no strobe on handler write", strobes_word(), 32'h0);
        chk("R9 enables", {29'd0, fault_en}, 32'h7);
        rd(6'h0C, d); chk("R9 R8 handler readback", d, 32'h0007_0000);
        wr(6'h0C, 32'h0002_0000);
        chk("R9 bus fault enable only", {29'd0, fault_en}, 32'h2);

        // R10 vector base
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, d); chk("R10 vector base alignment", d, 32'hFFFF_FF80);
        wr(6'h04, 32'h1234_567F);
        rd(6'h04, d); chk("R10 vector base value", d, 32'h1234_5600);

        // R11 reset control
        rd(6'h08, d); chk("R11 reset control read", d, 32'hFA05_0000);
        wr(6'h08, 32'h05FA_0006);
        chk("R11 keyed write requests", strobes_word(), 32'h0003_0000);
        wr(6'h08, 32'h05FA_0001);
        chk("R11 keyed reset via bit0", strobes_word(), 32'h0002_0000);
        wr(6'h08, 32'h1234_0007);
        chk("R11 wrong key ignored", strobes_word(), 32'h0);

        // R12 unmapped
        wr(6'h10, 32'hFFFF_FFFF);
        chk("R12 unmapped write no strobe", strobes_word(), 32'h0);
        chk("R12 unmapped write keeps enables", {29'd0, fault_en}, 32'h2);
        rd(6'h04, d); chk("R12 unmapped write keeps base", d, 32'h1234_5600);
        rd(6'h10, d); chk("R12 unmapped read", d, 32'h0);

        // R1 R10 reset clears stored state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 enables cleared by reset", {29'd0, fault_en}, 32'h0);
        rd(6'h04, d); chk("R10 base cleared by reset", d, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule